// File: doc/BRIEF.md
# Serial NAND Read Address Sequencer

This block produces the internal byte address stream for a read from a page-organised serial NAND array. A page holds 2048 data bytes followed by a 64-byte spare area, so it spans 2112 byte positions. A single-cycle start pulse captures a 32-bit row/column address and a read-mode select. From the cycle after that pulse, the block presents one array address per output byte. It moves to the next byte on each cycle in which the consumer holds read-enable high.

Two read modes are supported. A buffered read begins at the supplied column of the chosen page and stops after the last spare byte. A continuous read begins at column 0 of the chosen page, whatever column was supplied. It walks only the data bytes of each page and rolls on into the following pages and blocks without end. Alongside each address the block flags whether the byte lies in the spare area. It also pulses a strobe when a continuous read enters a new page.

Top module: `nand_rd_seq`

## Requirements
- R1: After synchronous reset, `valid_o`, `done_o`, `spare_o` and `page_cross_o` are all 0, and `addr_o` is 0.
- R2: `addr_o` uses the same layout as `addr_i`: block in bits 27:18, page in bits 17:12 and column in bits 11:0. Bits 31:28 of `addr_o` are always 0, and bits 31:28 of `addr_i` are ignored. `valid_o` is 1 in the cycle after a start pulse.
- R3: With `mode_i` = 1 (buffered), the first address after start carries the supplied block, page and column.
- R4: With `mode_i` = 0 (continuous), the first address after start carries the supplied block and page, with column 0.
- R5: The address advances by exactly one position only after a cycle in which `valid_o` and `rd_en_i` are both 1. Otherwise the address holds.
- R6: In a buffered read, the column runs upward through 2111. `spare_o` is 1 exactly when a valid address has a column from 2048 to 2111.
- R7: In a buffered read, accepting column 2111 drops `valid_o` and raises `done_o`. The address then holds until the next start. A buffered start with a column above 2111 goes straight to `done_o` = 1 and `valid_o` = 0.
- R8: In a continuous read, accepting column 2047 moves to column 0 of the next page, and `spare_o` never rises.
- R9: In a continuous read, leaving page 63 goes to page 0 of the next block, and leaving block 1023 goes to block 0.
- R10: In a continuous read, `page_cross_o` is 1 for exactly the one cycle in which the first address of a newly entered page is shown.
- R11: A start pulse abandons any read in progress, including a finished one, and loads the new address and mode. It takes priority over `rd_en_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle pulse that loads address and mode |
| mode_i | input | 1 | 1 = buffered single-page read, 0 = continuous read |
| addr_i | input | 32 | Start address (block, page, column) |
| rd_en_i | input | 1 | Consumer takes the current byte this cycle |
| addr_o | output | 32 | Current array byte address |
| valid_o | output | 1 | `addr_o` is a live read address |
| done_o | output | 1 | Buffered read has finished |
| spare_o | output | 1 | Current byte lies in the spare area |
| page_cross_o | output | 1 | First byte of a new page in a continuous read |

## Verification
The bench targets the page edges. In buffer mode, a sequencer that wrapped or ran on would show an address past 2111 or a cleared done flag. In continuous mode, one that failed to skip the spare area would show column 2048 and a raised spare flag. Block and array wrap are driven from page 63 of block 1023, where a carry error would leave the page at 63 or move to block 1024's alias. The bench also checks holds under a low read-enable, an out-of-range buffered column, and a restart that collides with read-enable. A design that gave read-enable priority over start would show the old stream's next address instead.

// File: rtl/nrs_pkg.sv
`timescale 1ns/1ps
package nrs_pkg;
  typedef enum logic {
    RD_CONT = 1'b0,
    RD_BUF  = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/nrs_col_ctr.sv
`timescale 1ns/1ps
// Column position within one page; knows where a page ends per mode.
module nrs_col_ctr #(
  parameter int COL_W       = 12,
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [COL_W-1:0] load_col_i,
  input  logic             adv_i,
  input  logic             buf_mode_i,
  output logic [COL_W-1:0] col_o,
  output logic             page_end_o,
  output logic             buf_last_o,
  output logic             in_spare_o
);
  localparam logic [COL_W-1:0] LAST_DATA = COL_W'(DATA_BYTES - 1);
  localparam logic [COL_W-1:0] LAST_COL  = COL_W'(DATA_BYTES + SPARE_BYTES - 1);
  localparam logic [COL_W-1:0] SPARE_LO  = COL_W'(DATA_BYTES);

  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
    end else if (load_i) begin
      col_q <= load_col_i;
    end else if (adv_i) begin
      if (page_end_o) col_q <= '0;
      else            col_q <= col_q + 1'b1;
    end
  end

  // Continuous reads leave the page after the last data byte.
  assign page_end_o = !buf_mode_i && (col_q == LAST_DATA);
  // Buffered reads stop on the last spare byte.
  assign buf_last_o = buf_mode_i && (col_q == LAST_COL);
  assign in_spare_o = (col_q >= SPARE_LO) && (col_q <= LAST_COL);
  assign col_o      = col_q;
endmodule

// File: rtl/nrs_row_ctr.sv
`timescale 1ns/1ps
// Page and block position; page carry ripples into block, block wraps at 2**BLK_W.
module nrs_row_ctr #(
  parameter int PAGE_W = 6,
  parameter int BLK_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] load_page_i,
  input  logic [BLK_W-1:0]  load_blk_i,
  input  logic              inc_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [BLK_W-1:0]  blk_o
);
  localparam logic [PAGE_W-1:0] LAST_PAGE = {PAGE_W{1'b1}};

  logic [PAGE_W-1:0] page_q;
  logic [BLK_W-1:0]  blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      blk_q  <= '0;
    end else if (load_i) begin
      page_q <= load_page_i;
      blk_q  <= load_blk_i;
    end else if (inc_i) begin
      page_q <= page_q + 1'b1;
      if (page_q == LAST_PAGE) blk_q <= blk_q + 1'b1;
    end
  end

  assign page_o = page_q;
  assign blk_o  = blk_q;
endmodule

// File: rtl/nand_rd_seq.sv
`timescale 1ns/1ps
module nand_rd_seq #(
  parameter int ADDR_W      = 32,
  parameter int COL_W       = 12,
  parameter int PAGE_W      = 6,
  parameter int BLK_W       = 10,
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              done_o,
  output logic              spare_o,
  output logic              page_cross_o
);
  import nrs_pkg::*;

  localparam int PAGE_LSB = COL_W;
  localparam int BLK_LSB  = COL_W + PAGE_W;
  localparam int USED_W   = BLK_LSB + BLK_W;
  localparam int PAD_W    = ADDR_W - USED_W;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(DATA_BYTES + SPARE_BYTES - 1);

  rd_mode_e          mode_q;
  logic              valid_q, done_q, cross_q;
  logic [COL_W-1:0]  col;
  logic [PAGE_W-1:0] page;
  logic [BLK_W-1:0]  blk;
  logic              page_end, buf_last, in_spare;

  rd_mode_e          mode_in;
  logic [COL_W-1:0]  col_in;
  logic [COL_W-1:0]  load_col;
  logic              take, adv, bad_start;

  assign mode_in   = rd_mode_e'(mode_i);
  assign col_in    = addr_i[COL_W-1:0];
  assign load_col  = (mode_in == RD_BUF) ? col_in : '0;
  assign bad_start = (mode_in == RD_BUF) && (col_in > LAST_COL);
  assign take      = valid_q && rd_en_i && !start_i;
  assign adv       = take && !buf_last;

  nrs_col_ctr #(
    .COL_W      (COL_W),
    .DATA_BYTES (DATA_BYTES),
    .SPARE_BYTES(SPARE_BYTES)
  ) u_col (
    .clk       (clk),
    .rst       (rst),
    .load_i    (start_i),
    .load_col_i(load_col),
    .adv_i     (adv),
    .buf_mode_i(mode_q == RD_BUF),
    .col_o     (col),
    .page_end_o(page_end),
    .buf_last_o(buf_last),
    .in_spare_o(in_spare)
  );

  nrs_row_ctr #(
    .PAGE_W(PAGE_W),
    .BLK_W (BLK_W)
  ) u_row (
    .clk        (clk),
    .rst        (rst),
    .load_i     (start_i),
    .load_page_i(addr_i[PAGE_LSB +: PAGE_W]),
    .load_blk_i (addr_i[BLK_LSB +: BLK_W]),
    .inc_i      (adv && page_end),
    .page_o     (page),
    .blk_o      (blk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= RD_CONT;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      cross_q <= 1'b0;
    end else if (start_i) begin
      mode_q  <= mode_in;
      valid_q <= !bad_start;
      done_q  <= bad_start;
      cross_q <= 1'b0;
    end else if (take) begin
      if (buf_last) begin
        valid_q <= 1'b0;
        done_q  <= 1'b1;
      end
      cross_q <= page_end;
    end else begin
      cross_q <= 1'b0;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign addr_o = {{PAD_W{1'b0}}, blk, page, col};
    end else begin : g_nopad
      assign addr_o = {blk, page, col};
    end
  endgenerate

  assign valid_o      = valid_q;
  assign done_o       = done_q;
  assign spare_o      = valid_q && (mode_q == RD_BUF) && in_spare;
  assign page_cross_o = cross_q;
endmodule

// File: rtl/nrs_checker.sv
`timescale 1ns/1ps
module nrs_checker #(
  parameter int ADDR_W      = 32,
  parameter int COL_W       = 12,
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              mode_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              valid_o,
  input logic              done_o,
  input logic              spare_o,
  input logic              page_cross_o,
  input logic              buf_mode
);
  localparam logic [COL_W-1:0] LAST_DATA = COL_W'(DATA_BYTES - 1);
  localparam logic [COL_W-1:0] LAST_COL  = COL_W'(DATA_BYTES + SPARE_BYTES - 1);

  AST_CONT_START_COL0: assert property (@(posedge clk) disable iff (rst)
    start_i && !mode_i |=> valid_o && addr_o[COL_W-1:0] == '0); // R4
  AST_HOLD_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
    valid_o && !rd_en_i && !start_i |=> valid_o && $stable(addr_o)); // R5
  AST_BUF_STOP: assert property (@(posedge clk) disable iff (rst)
    valid_o && buf_mode && rd_en_i && !start_i && addr_o[COL_W-1:0] == LAST_COL
    |=> done_o && !valid_o && $stable(addr_o)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done_o && !start_i |=> done_o && $stable(addr_o)); // R7
  AST_DONE_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
    !(done_o && valid_o)); // R7
  AST_NO_SPARE_CONT: assert property (@(posedge clk) disable iff (rst)
    !buf_mode |-> !spare_o); // R8
  AST_CONT_SKIP_SPARE: assert property (@(posedge clk) disable iff (rst)
    valid_o && !buf_mode && rd_en_i && !start_i && addr_o[COL_W-1:0] == LAST_DATA
    |=> addr_o[COL_W-1:0] == '0 && page_cross_o); // R8
  AST_CROSS_AT_COL0: assert property (@(posedge clk) disable iff (rst)
    page_cross_o |-> valid_o && !buf_mode && addr_o[COL_W-1:0] == '0); // R10
  AST_START_WINS: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !page_cross_o); // R11
endmodule

bind nand_rd_seq nrs_checker #(
  .ADDR_W     (ADDR_W),
  .COL_W      (COL_W),
  .DATA_BYTES (DATA_BYTES),
  .SPARE_BYTES(SPARE_BYTES)
) u_nrs_checker (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .mode_i      (mode_i),
  .rd_en_i     (rd_en_i),
  .addr_o      (addr_o),
  .valid_o     (valid_o),
  .done_o      (done_o),
  .spare_o     (spare_o),
  .page_cross_o(page_cross_o),
  .buf_mode    (mode_q == nrs_pkg::RD_BUF)
);

// File: tb/test_nand_rd_seq.sv
`timescale 1ns/1ps
module test_nand_rd_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] addr_o;
  logic        valid_o, done_o, spare_o, page_cross_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nand_rd_seq i_nand_rd_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i), .addr_i(addr_i),
    .rd_en_i(rd_en_i), .addr_o(addr_o), .valid_o(valid_o), .done_o(done_o),
    .spare_o(spare_o), .page_cross_o(page_cross_o)
  );

  function automatic logic [31:0] mk(input int blk, input int pg, input int col);
    return {4'h0, 10'(blk), 6'(pg), 12'(col)};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic begin_read(input logic m, input logic [31:0] a);
    start_i = 1'b1; mode_i = m; addr_i = a;
    tick();
    start_i = 1'b0;
  endtask

  task automatic advance(input int n);
    rd_en_i = 1'b1;
    repeat (n) tick();
    rd_en_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "valid", valid_o, 0);
    chk("R1", "done", done_o, 0);
    chk("R1", "spare", spare_o, 0);
    chk("R1", "cross", page_cross_o, 0);
    chk("R1", "addr", addr_o, 0);
  endtask

  task automatic t_buffer_tail();
    begin_read(1'b1, {4'hF, 10'd5, 6'd7, 12'd2100});
    chk("R2", "upper bits ignored, valid", {addr_o[31:1], valid_o}, {mk(5, 7, 2100)[31:1], 1'b1});
    chk("R3", "start addr", addr_o, mk(5, 7, 2100));
    chk("R6", "spare at 2100", spare_o, 1);
    tick(); tick();
    chk("R5", "hold without enable", addr_o, mk(5, 7, 2100));
    advance(1);
    chk("R5", "single step", addr_o, mk(5, 7, 2101));
    advance(10);
    chk("R6", "reaches 2111", addr_o, mk(5, 7, 2111));
    chk("R6", "still valid at 2111", valid_o, 1);
    advance(1);
    chk("R7", "done after 2111", {done_o, valid_o}, 2'b10);
    chk("R7", "addr held", addr_o, mk(5, 7, 2111));
    advance(3);
    chk("R7", "no wrap after done", addr_o, mk(5, 7, 2111));
    chk("R7", "done sticky", done_o, 1);
  endtask

  task automatic t_buffer_spare_edge();
    begin_read(1'b1, mk(9, 0, 2046));
    chk("R6", "no spare at 2046", spare_o, 0);
    advance(1);
    chk("R6", "no spare at 2047", spare_o, 0);
    advance(1);
    chk("R6", "col 2048 not skipped", addr_o, mk(9, 0, 2048));
    chk("R6", "spare at 2048", spare_o, 1);
    chk("R10", "no cross in buffer mode", page_cross_o, 0);
  endtask

  task automatic t_buffer_bad_col();
    begin_read(1'b1, mk(2, 3, 3000));
    chk("R7", "out-of-range column done", {done_o, valid_o}, 2'b10);
  endtask

  task automatic t_continuous();
    bit saw_spare = 1'b0;
    begin_read(1'b0, mk(3, 10, 2040));
    chk("R4", "column forced to 0", addr_o, mk(3, 10, 0));
    chk("R11", "done cleared by start", done_o, 0);
    rd_en_i = 1'b1;
    for (int i = 0; i < 2047; i++) begin
      tick();
      if (spare_o) saw_spare = 1'b1;
    end
    rd_en_i = 1'b0;
    chk("R8", "at last data byte", addr_o, mk(3, 10, 2047));
    chk("R8", "no spare seen", saw_spare, 0);
    advance(1);
    chk("R8", "skip to next page", addr_o, mk(3, 11, 0));
    chk("R10", "cross pulse", page_cross_o, 1);
    tick();
    chk("R10", "cross one cycle", page_cross_o, 0);
  endtask

  task automatic t_block_wrap();
    begin_read(1'b0, mk(4, 63, 0));
    advance(2048);
    chk("R9", "page 63 to next block", addr_o, mk(5, 0, 0));
    begin_read(1'b0, mk(1023, 63, 17));
    advance(2048);
    chk("R9", "last block wraps", addr_o, mk(0, 0, 0));
    chk("R10", "cross on wrap", page_cross_o, 1);
  endtask

  task automatic t_restart();
    begin_read(1'b1, mk(1, 1, 5));
    rd_en_i = 1'b1;
    tick(); tick();
    start_i = 1'b1; mode_i = 1'b0; addr_i = mk(2, 2, 100);
    tick();
    start_i = 1'b0; rd_en_i = 1'b0;
    chk("R11", "start wins over enable", addr_o, mk(2, 2, 0));
    chk("R11", "valid after restart", valid_o, 1);
    chk("R11", "no spare in new mode", spare_o, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    t_reset();
    t_buffer_tail();
    t_buffer_spare_edge();
    t_buffer_bad_col();
    t_continuous();
    t_block_wrap();
    t_restart();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule